// File: doc/BRIEF.md
# Read Tag and Completion Tracker

This block sits between several read-request clients (for example two descriptor fetchers and a DMA read engine) and the transmit side of a PCIe endpoint. A client raises a request together with the byte length of the read it wants to issue. The tracker grants a transaction tag only when three conditions hold: a tag is free, a header slot is free in the local completion buffer, and enough data space is free for the whole read. It allocates the lowest free tag. When several clients request in the same cycle, it chooses among them round-robin.

The tracker watches the receive completion stream and matches each completion to its tag. Completions for different tags may arrive in any order, and a read may be split across several completions. A tag is retired only by the completion that carries the last bytes of its read. When the tag is retired, its header and data credit go back to the budget.

Every outstanding read has its own age counter. A read that gets no final completion within the timeout window is retired and flagged on a per-tag timeout output, so the owning client can retry it. A completion that matches no outstanding tag is discarded, and a sticky flag records that it arrived.

Top module: `read_tag_tracker`

## Requirements
- R1: After reset all tags are free, no grant is given, header credit is `HDR_CREDITS`, data credit is `DATA_CREDITS`, and `doneValid`, `timeoutVec` and `unexpectedCpl` are all zero.
- R2: A grant is combinational in the cycle of the request. `grantValid` is one-hot (bit i for client i), and `grantTag` is the lowest-numbered free tag.
- R3: Among clients that request and fit in the same cycle, the search for the grant starts at the client after the one granted last (client 0 first after reset).
- R4: A granted tag is not granted again until it has been retired, either by its final completion or by its timeout.
- R5: Each grant takes one header credit. No grant is given while header credit is zero. Credit changes are visible on `hdrCreditFree` in the cycle after the clock edge.
- R6: Each grant takes ceil(bytes/16) data credits. A client whose need exceeds `dataCreditFree` is skipped, while another client that fits may be granted in the same cycle.
- R7: A completion for a busy tag retires that tag only when its remaining byte count equals its payload byte count. In the next cycle `doneValid` is 1, `doneTag` holds the tag, and both credits are returned. A non-final completion changes nothing visible.
- R8: Completions are accepted in any tag order. Each one retires its own tag and returns that tag's own data credit.
- R9: A tag that is still busy `TIMEOUT_CYCLES` clock edges after its grant edge is retired. Its bit in `timeoutVec` pulses for exactly one cycle, and its credits are returned.
- R10: A completion whose tag is not busy, including one arriving after a timeout, produces no `doneValid` and leaves the credits unchanged. It sets `unexpectedCpl`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CLIENTS | Per-client read request |
| reqBytes | input | NUM_CLIENTS*LEN_W | Per-client read length in bytes, client c at bits [c*LEN_W +: LEN_W] |
| grantValid | output | NUM_CLIENTS | One-hot grant, same cycle as the request |
| grantTag | output | TAG_W | Tag given with the grant |
| cplValid | input | 1 | A completion header is present on the receive side |
| cplTag | input | TAG_W | Tag of the completion |
| cplPayloadBytes | input | LEN_W | Payload bytes carried by this completion |
| cplRemainBytes | input | LEN_W | Remaining byte count reported by this completion |
| doneValid | output | 1 | A tag was retired by its final completion (pulse) |
| doneTag | output | TAG_W | Tag retired by completion |
| timeoutVec | output | 2**TAG_W | Per-tag timeout pulse |
| hdrCreditFree | output | clog2(HDR_CREDITS+1) | Free header credit |
| dataCreditFree | output | clog2(DATA_CREDITS+1) | Free data credit, 16-byte units |
| unexpectedCpl | output | 1 | Sticky: a completion matched no outstanding tag |

## Verification
A corrupt busy bitmap shows up at once on the ports. Either a tag that is still outstanding is granted again on the next request, or a legitimate completion is reported as unexpected on the cycle after it arrives. Credit bookkeeping errors appear on the credit outputs in the cycle after the edge that caused them, and they decide whether the next request is granted. A wrong age counter is only seen at the end of the timeout window: the per-tag pulse comes early, comes late or never comes. The timeout check therefore samples the cycle just before the expected pulse, the cycle of the pulse and the cycle just after it.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  // Strobes the control side raises for the datapath in one cycle.
  typedef struct packed {
    logic alloc;     // a tag is granted on this edge
    logic cplHit;    // a completion matches a busy tag
    logic cplFinal;  // that completion carries the last bytes
    logic cplMiss;   // a completion matches no busy tag
  } rttStrobes_t;

endpackage

// File: rtl/rtt_low_free.sv
module rtt_low_free #(
  parameter int TAG_W    = 5,
  parameter int NUM_TAGS = 1 << TAG_W
) (
  input  logic [NUM_TAGS-1:0] busyVec,
  output logic                anyFree,
  output logic [TAG_W-1:0]    lowTag
);

  // Scan from the top down so that the last hit is the lowest free tag.
  always_comb begin
    anyFree = 1'b0;
    lowTag  = '0;
    for (int t = NUM_TAGS - 1; t >= 0; t--) begin
      if (!busyVec[t]) begin
        anyFree = 1'b1;
        lowTag  = TAG_W'(t);
      end
    end
  end

endmodule

// File: rtl/rtt_control.sv
module rtt_control
  import rtt_pkg::*;
#(
  parameter int NUM_CLIENTS = 3,
  parameter int TAG_W       = 5,
  parameter int LEN_W       = 13,
  parameter int HCW         = 4,
  parameter int DCW         = 7,
  parameter int NEED_W      = LEN_W - 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CLIENTS-1:0]       reqValid,
  input  logic [NUM_CLIENTS*LEN_W-1:0] reqBytes,
  input  logic [(1<<TAG_W)-1:0]        busyVec,
  input  logic [HCW-1:0]               hdrFree,
  input  logic [DCW-1:0]               dataFree,
  input  logic                         cplValid,
  input  logic [TAG_W-1:0]             cplTag,
  input  logic [LEN_W-1:0]             cplPayloadBytes,
  input  logic [LEN_W-1:0]             cplRemainBytes,
  output logic [NUM_CLIENTS-1:0]       grantValid,
  output logic [TAG_W-1:0]             grantTag,
  output logic [NEED_W-1:0]            allocNeed,
  output rttStrobes_t                  strobes
);

  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int CLI_W    = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;
  localparam int CMP_W    = (DCW > NEED_W) ? DCW : NEED_W;

  logic                  anyFree;
  logic [TAG_W-1:0]      lowTag;
  logic [NEED_W-1:0]     needVec [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] fits;
  logic [CLI_W-1:0]      rrPtr;
  logic [CLI_W-1:0]      pick;
  logic                  found;
  int                    cIdx;

  rtt_low_free #(.TAG_W(TAG_W), .NUM_TAGS(NUM_TAGS)) u_lowFree (
    .busyVec (busyVec),
    .anyFree (anyFree),
    .lowTag  (lowTag)
  );

  // Data credit need per client: ceil(bytes / 16), plus the fit test.
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_need
    logic [LEN_W:0] roundUp;
    assign roundUp    = {1'b0, reqBytes[c*LEN_W +: LEN_W]} + (LEN_W+1)'(15);
    assign needVec[c] = roundUp[LEN_W:4];
    assign fits[c]    = anyFree && (hdrFree != '0) &&
                        (CMP_W'(dataFree) >= CMP_W'(needVec[c]));
  end

  // Round-robin search that starts after the last client granted.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cIdx  = 0;
    for (int k = 0; k < NUM_CLIENTS; k++) begin
      cIdx = int'(rrPtr) + k;
      if (cIdx >= NUM_CLIENTS) cIdx = cIdx - NUM_CLIENTS;
      if (!found && reqValid[cIdx] && fits[cIdx]) begin
        found = 1'b1;
        pick  = CLI_W'(cIdx);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      grantValid[c] = found && (pick == CLI_W'(c));
    end
  end

  assign grantTag  = lowTag;
  assign allocNeed = needVec[pick];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (found) begin
      rrPtr <= (int'(pick) == NUM_CLIENTS - 1) ? '0 : pick + CLI_W'(1);
    end
  end

  // Completion decode.
  always_comb begin
    strobes.alloc    = found;
    strobes.cplHit   = cplValid && busyVec[cplTag];
    strobes.cplFinal = strobes.cplHit && (cplRemainBytes == cplPayloadBytes);
    strobes.cplMiss  = cplValid && !busyVec[cplTag];
  end

endmodule

// File: rtl/rtt_datapath.sv
module rtt_datapath
  import rtt_pkg::*;
#(
  parameter int TAG_W          = 5,
  parameter int HDR_CREDITS    = 8,
  parameter int DATA_CREDITS   = 64,
  parameter int HCW            = 4,
  parameter int DCW            = 7,
  parameter int NEED_W         = 10,
  parameter int TIMEOUT_CYCLES = 200,
  parameter int TMR_W          = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rttStrobes_t             strobes,
  input  logic [TAG_W-1:0]        allocTag,
  input  logic [NEED_W-1:0]       allocNeed,
  input  logic [TAG_W-1:0]        cplTag,
  output logic [(1<<TAG_W)-1:0]   busyVec,
  output logic [HCW-1:0]          hdrFree,
  output logic [DCW-1:0]          dataFree,
  output logic                    doneValid,
  output logic [TAG_W-1:0]        doneTag,
  output logic [(1<<TAG_W)-1:0]   timeoutVec,
  output logic                    unexpectedCpl
);

  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int SUM_W    = NEED_W + TAG_W;

  logic [TMR_W-1:0]    ageCnt  [NUM_TAGS];
  logic [NEED_W-1:0]   needMem [NUM_TAGS];
  logic [NUM_TAGS-1:0] expireVec;
  logic [NUM_TAGS-1:0] releaseVec;
  logic [TAG_W:0]      hdrRet;
  logic [SUM_W-1:0]    dataRet;
  logic [HCW-1:0]      hdrNext;
  logic [DCW-1:0]      dataNext;

  // A final completion on the expiring edge wins over the timeout.
  always_comb begin
    hdrRet  = '0;
    dataRet = '0;
    for (int t = 0; t < NUM_TAGS; t++) begin
      expireVec[t]  = busyVec[t] && (ageCnt[t] == TMR_W'(TIMEOUT_CYCLES - 1)) &&
                      !(strobes.cplFinal && (cplTag == TAG_W'(t)));
      releaseVec[t] = expireVec[t] || (strobes.cplFinal && (cplTag == TAG_W'(t)));
      if (releaseVec[t]) begin
        hdrRet  = hdrRet + (TAG_W+1)'(1);
        dataRet = dataRet + SUM_W'(needMem[t]);
      end
    end
    hdrNext  = HCW'(int'(hdrFree) + int'(hdrRet) - (strobes.alloc ? 1 : 0));
    dataNext = DCW'(int'(dataFree) + int'(dataRet) -
                    (strobes.alloc ? int'(allocNeed) : 0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyVec       <= '0;
      hdrFree       <= HCW'(HDR_CREDITS);
      dataFree      <= DCW'(DATA_CREDITS);
      doneValid     <= 1'b0;
      doneTag       <= '0;
      timeoutVec    <= '0;
      unexpectedCpl <= 1'b0;
      for (int t = 0; t < NUM_TAGS; t++) begin
        ageCnt[t]  <= '0;
        needMem[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        if (strobes.alloc && (allocTag == TAG_W'(t))) begin
          busyVec[t] <= 1'b1;
          ageCnt[t]  <= '0;
          needMem[t] <= allocNeed;
        end else if (releaseVec[t]) begin
          busyVec[t] <= 1'b0;
        end else if (busyVec[t]) begin
          ageCnt[t]  <= ageCnt[t] + TMR_W'(1);
        end
      end
      hdrFree       <= hdrNext;
      dataFree      <= dataNext;
      doneValid     <= strobes.cplFinal;
      doneTag       <= cplTag;
      timeoutVec    <= expireVec;
      unexpectedCpl <= unexpectedCpl | strobes.cplMiss;
    end
  end

endmodule

// File: rtl/read_tag_tracker.sv
module read_tag_tracker
  import rtt_pkg::*;
#(
  parameter int NUM_CLIENTS    = 3,
  parameter int TAG_W          = 5,
  parameter int LEN_W          = 13,
  parameter int HDR_CREDITS    = 8,
  parameter int DATA_CREDITS   = 64,
  parameter int TIMEOUT_CYCLES = 200
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_CLIENTS-1:0]                reqValid,
  input  logic [NUM_CLIENTS*LEN_W-1:0]          reqBytes,
  output logic [NUM_CLIENTS-1:0]                grantValid,
  output logic [TAG_W-1:0]                      grantTag,
  input  logic                                  cplValid,
  input  logic [TAG_W-1:0]                      cplTag,
  input  logic [LEN_W-1:0]                      cplPayloadBytes,
  input  logic [LEN_W-1:0]                      cplRemainBytes,
  output logic                                  doneValid,
  output logic [TAG_W-1:0]                      doneTag,
  output logic [(1<<TAG_W)-1:0]                 timeoutVec,
  output logic [$clog2(HDR_CREDITS+1)-1:0]      hdrCreditFree,
  output logic [$clog2(DATA_CREDITS+1)-1:0]     dataCreditFree,
  output logic                                  unexpectedCpl
);

  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int HCW      = $clog2(HDR_CREDITS + 1);
  localparam int DCW      = $clog2(DATA_CREDITS + 1);
  localparam int NEED_W   = LEN_W - 3;
  localparam int TMR_W    = $clog2(TIMEOUT_CYCLES + 1);

  rttStrobes_t         strobes;
  logic [NUM_TAGS-1:0] busyVec;
  logic [NEED_W-1:0]   allocNeed;

  rtt_control #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .TAG_W       (TAG_W),
    .LEN_W       (LEN_W),
    .HCW         (HCW),
    .DCW         (DCW),
    .NEED_W      (NEED_W)
  ) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .reqValid        (reqValid),
    .reqBytes        (reqBytes),
    .busyVec         (busyVec),
    .hdrFree         (hdrCreditFree),
    .dataFree        (dataCreditFree),
    .cplValid        (cplValid),
    .cplTag          (cplTag),
    .cplPayloadBytes (cplPayloadBytes),
    .cplRemainBytes  (cplRemainBytes),
    .grantValid      (grantValid),
    .grantTag        (grantTag),
    .allocNeed       (allocNeed),
    .strobes         (strobes)
  );

  rtt_datapath #(
    .TAG_W          (TAG_W),
    .HDR_CREDITS    (HDR_CREDITS),
    .DATA_CREDITS   (DATA_CREDITS),
    .HCW            (HCW),
    .DCW            (DCW),
    .NEED_W         (NEED_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .TMR_W          (TMR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .allocTag      (grantTag),
    .allocNeed     (allocNeed),
    .cplTag        (cplTag),
    .busyVec       (busyVec),
    .hdrFree       (hdrCreditFree),
    .dataFree      (dataCreditFree),
    .doneValid     (doneValid),
    .doneTag       (doneTag),
    .timeoutVec    (timeoutVec),
    .unexpectedCpl (unexpectedCpl)
  );

endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int NUM_CLIENTS  = 3,
  parameter int TAG_W        = 5,
  parameter int HDR_CREDITS  = 8,
  parameter int DATA_CREDITS = 64
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [NUM_CLIENTS-1:0]            reqValid,
  input logic [NUM_CLIENTS-1:0]            grantValid,
  input logic [TAG_W-1:0]                  grantTag,
  input logic [(1<<TAG_W)-1:0]             busyVec,
  input logic [$clog2(HDR_CREDITS+1)-1:0]  hdrCreditFree,
  input logic [$clog2(DATA_CREDITS+1)-1:0] dataCreditFree,
  input logic                              cplValid,
  input logic [TAG_W-1:0]                  cplTag,
  input logic                              doneValid,
  input logic [TAG_W-1:0]                  doneTag,
  input logic [(1<<TAG_W)-1:0]             timeoutVec,
  input logic                              unexpectedCpl
);

  // R2, R3: at most one client is granted, and only a client that asked.
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantValid) && ((grantValid & ~reqValid) == '0));

  // R4: a granted tag is never one that is still outstanding.
  p_grant_free_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid != '0) |-> !busyVec[grantTag]);

  // R5: no grant without header credit; header credit stays within budget.
  p_hdr_credit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((grantValid != '0) |-> (hdrCreditFree != '0)) and
    (int'(hdrCreditFree) <= HDR_CREDITS));

  // R6: data credit stays within budget.
  p_data_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(dataCreditFree) <= DATA_CREDITS);

  // R7: a retirement follows a completion to that same busy tag.
  p_done_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($past(cplValid) && ($past(cplTag) == doneTag) &&
                   $past(busyVec[cplTag])));

  // R9: only busy tags time out, and they are free afterwards.
  p_timeout_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutVec != '0) |-> (((timeoutVec & ~$past(busyVec)) == '0) &&
                            ((timeoutVec & busyVec) == '0)));

  // R10: the unexpected-completion flag is sticky.
  p_sticky_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    unexpectedCpl |=> unexpectedCpl);

endmodule

bind read_tag_tracker rtt_checker #(
  .NUM_CLIENTS  (NUM_CLIENTS),
  .TAG_W        (TAG_W),
  .HDR_CREDITS  (HDR_CREDITS),
  .DATA_CREDITS (DATA_CREDITS)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .reqValid       (reqValid),
  .grantValid     (grantValid),
  .grantTag       (grantTag),
  .busyVec        (busyVec),
  .hdrCreditFree  (hdrCreditFree),
  .dataCreditFree (dataCreditFree),
  .cplValid       (cplValid),
  .cplTag         (cplTag),
  .doneValid      (doneValid),
  .doneTag        (doneTag),
  .timeoutVec     (timeoutVec),
  .unexpectedCpl  (unexpectedCpl)
);

// File: tb/read_tag_tracker_tb.sv
`timescale 1ns/1ps
module read_tag_tracker_tb;

  localparam int NC    = 3;
  localparam int TAG_W = 5;
  localparam int NT    = 1 << TAG_W;
  localparam int LEN_W = 13;
  localparam int HDRC  = 8;
  localparam int DATAC = 64;
  localparam int TMO   = 200;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [NC-1:0]          reqValid = '0;
  logic [NC*LEN_W-1:0]    reqBytes = '0;
  logic [NC-1:0]          grantValid;
  logic [TAG_W-1:0]       grantTag;
  logic                   cplValid = 1'b0;
  logic [TAG_W-1:0]       cplTag = '0;
  logic [LEN_W-1:0]       cplPayloadBytes = '0;
  logic [LEN_W-1:0]       cplRemainBytes = '0;
  logic                   doneValid;
  logic [TAG_W-1:0]       doneTag;
  logic [NT-1:0]          timeoutVec;
  logic [$clog2(HDRC+1)-1:0]  hdrCreditFree;
  logic [$clog2(DATAC+1)-1:0] dataCreditFree;
  logic                   unexpectedCpl;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  read_tag_tracker u_dut (
    .clk             (clk),
    .rstN            (rstN),
    .reqValid        (reqValid),
    .reqBytes        (reqBytes),
    .grantValid      (grantValid),
    .grantTag        (grantTag),
    .cplValid        (cplValid),
    .cplTag          (cplTag),
    .cplPayloadBytes (cplPayloadBytes),
    .cplRemainBytes  (cplRemainBytes),
    .doneValid       (doneValid),
    .doneTag         (doneTag),
    .timeoutVec      (timeoutVec),
    .hdrCreditFree   (hdrCreditFree),
    .dataCreditFree  (dataCreditFree),
    .unexpectedCpl   (unexpectedCpl)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = '0; cplValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Single client request; checks the grant and returns the tag.
  task automatic grantOne(input int c, input int bytes, input string req, output int tag);
    reqValid = '0;
    reqValid[c] = 1'b1;
    reqBytes[c*LEN_W +: LEN_W] = LEN_W'(bytes);
    #1;
    chk({req, " grant client"}, grantValid, 1 << c);
    tag = int'(grantTag);
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic sendCpl(input int tag, input int payload, input int remain);
    cplValid = 1'b1;
    cplTag = TAG_W'(tag);
    cplPayloadBytes = LEN_W'(payload);
    cplRemainBytes = LEN_W'(remain);
    @(negedge clk);
    cplValid = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 grant idle", grantValid, 0);
    chk("R1 hdr credit", hdrCreditFree, HDRC);
    chk("R1 data credit", dataCreditFree, DATAC);
    chk("R1 done idle", doneValid, 0);
    chk("R1 timeout idle", timeoutVec, 0);
    chk("R1 flag clear", unexpectedCpl, 0);
  endtask

  task automatic t_lowest();
    int tg;
    doReset();
    grantOne(0, 16, "R2", tg); chk("R2 first tag", tg, 0);
    grantOne(0, 16, "R2", tg); chk("R2 second tag", tg, 1);
    grantOne(0, 16, "R2", tg); chk("R2 third tag", tg, 2);
    sendCpl(1, 16, 16);
    chk("R7 done tag1", doneValid, 1);
    chk("R7 done tag value", doneTag, 1);
    grantOne(1, 16, "R2", tg); chk("R2 reuse lowest freed tag", tg, 1);
    grantOne(2, 16, "R4", tg); chk("R4 skip busy tags", tg, 3);
  endtask

  task automatic t_roundRobin();
    int expC[4] = '{0, 1, 2, 0};
    doReset();
    for (int c = 0; c < NC; c++) reqBytes[c*LEN_W +: LEN_W] = LEN_W'(16);
    reqValid = '1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R3 rotation client", grantValid, 1 << expC[k]);
      chk("R4 distinct tag", grantTag, k);
      @(negedge clk);
    end
    reqValid = '0;
  endtask

  task automatic t_hdrCredit();
    int tg;
    doReset();
    for (int k = 0; k < HDRC; k++) grantOne(0, 16, "R5", tg);
    chk("R5 hdr exhausted", hdrCreditFree, 0);
    reqValid[0] = 1'b1;
    #1;
    chk("R5 no grant without hdr credit", grantValid, 0);
    @(negedge clk);
    reqValid = '0;
    sendCpl(0, 16, 16);
    chk("R5 hdr returned", hdrCreditFree, 1);
    grantOne(0, 16, "R5", tg); chk("R5 grant after return", tg, 0);
  endtask

  task automatic t_dataCredit();
    int tg;
    doReset();
    grantOne(0, 1000, "R6", tg);
    chk("R6 data taken ceil(1000/16)", dataCreditFree, DATAC - 63);
    reqValid[1] = 1'b1;
    reqBytes[1*LEN_W +: LEN_W] = LEN_W'(17);
    #1;
    chk("R6 too large client refused", grantValid, 0);
    reqValid[2] = 1'b1;
    reqBytes[2*LEN_W +: LEN_W] = LEN_W'(16);
    #1;
    chk("R6 fitting client granted past large one", grantValid, 3'b100);
    @(negedge clk);
    reqValid = '0;
    chk("R6 data exhausted", dataCreditFree, 0);
    sendCpl(0, 1000, 1000);
    chk("R6 data returned", dataCreditFree, 63);
    chk("R6 hdr after return", hdrCreditFree, HDRC - 1);
  endtask

  task automatic t_split();
    int tg;
    doReset();
    grantOne(0, 64, "R7", tg);
    chk("R7 data reserved", dataCreditFree, DATAC - 4);
    sendCpl(tg, 32, 64);
    chk("R7 partial no done", doneValid, 0);
    chk("R7 partial keeps data", dataCreditFree, DATAC - 4);
    chk("R7 partial keeps hdr", hdrCreditFree, HDRC - 1);
    sendCpl(tg, 32, 32);
    chk("R7 final done", doneValid, 1);
    chk("R7 final tag", doneTag, tg);
    chk("R7 data back", dataCreditFree, DATAC);
    chk("R7 hdr back", hdrCreditFree, HDRC);
  endtask

  task automatic t_outOfOrder();
    int tg;
    doReset();
    grantOne(0, 16, "R8", tg);
    grantOne(1, 32, "R8", tg);
    grantOne(2, 48, "R8", tg);
    chk("R8 data after three", dataCreditFree, DATAC - 6);
    sendCpl(2, 48, 48);
    chk("R8 tag2 first", doneTag, 2);
    chk("R8 data tag2 returned", dataCreditFree, DATAC - 3);
    sendCpl(0, 16, 16);
    chk("R8 tag0 second", doneTag, 0);
    chk("R8 data tag0 returned", dataCreditFree, DATAC - 2);
    sendCpl(1, 32, 32);
    chk("R8 tag1 last", doneValid, 1);
    chk("R8 all data back", dataCreditFree, DATAC);
  endtask

  task automatic t_timeoutLate();
    int tg;
    doReset();
    grantOne(1, 100, "R9", tg);
    chk("R9 data reserved", dataCreditFree, DATAC - 7);
    repeat (TMO - 1) @(negedge clk);
    chk("R9 no early timeout", timeoutVec, 0);
    chk("R9 still holds hdr", hdrCreditFree, HDRC - 1);
    @(negedge clk);
    chk("R9 timeout pulse", timeoutVec, 1);
    chk("R9 hdr returned", hdrCreditFree, HDRC);
    chk("R9 data returned", dataCreditFree, DATAC);
    @(negedge clk);
    chk("R9 pulse one cycle", timeoutVec, 0);
    sendCpl(tg, 100, 100);
    chk("R10 late cpl no done", doneValid, 0);
    chk("R10 flag set", unexpectedCpl, 1);
    chk("R10 hdr unchanged", hdrCreditFree, HDRC);
    chk("R10 data unchanged", dataCreditFree, DATAC);
    @(negedge clk);
    chk("R10 flag sticky", unexpectedCpl, 1);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    t_reset();
    t_lowest();
    t_roundRobin();
    t_hdrCredit();
    t_dataCredit();
    t_split();
    t_outOfOrder();
    t_timeoutLate();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule